// File: doc/BRIEF.md
# Pipelined Byte-Write SRAM Core

This block is the storage array and data path of a synchronous pipelined SRAM with an 18-bit word. The word is split into two 9-bit halves. Each half carries eight data bits and one parity bit, and each half can be written on its own. An upstream address sequencer presents a word address and a select strobe on each clock. The write data and write controls arrive on the same edge. Everything is captured on the rising edge. A write is committed to the array one clock later, with no further action needed from the driver of the interface.

Read data passes through an output register. A read presented before edge N is visible on the output after edge N+1. A read issued in the cycle right after a write sees the new contents of every half that write touched. Deselection follows the same pipeline, so a deselected cycle only silences the output one clock later and never cuts off the beat already in flight. The output enable acts on the output at once, with no clock involved. When nothing is valid, the output is parked at zero and the valid flag is low, instead of being tristated.

Top module: `sram_pipe_core`

## Requirements
- R1: While reset is high and in the cycle after it is released, `rd_valid` is 0 and `rd_data` is all zeros.
- R2: A selected cycle with no half write-qualified is a read. Its word is on `rd_data` with `rd_valid` high after the second rising edge, counting the edge that captured it, provided `oe_n` is low.
- R3: With `gw_n` low, a selected cycle writes both halves, whatever the values of `bwe_n`, `we_lo_n` and `we_hi_n`.
- R4: The word layout is as follows. The low half is data bits 7:0 plus parity bit 16. The high half is data bits 15:8 plus parity bit 17. With `gw_n` high and `bwe_n` low, `we_lo_n` low writes the low half only, and `we_hi_n` low writes the high half only.
- R5: With `gw_n` and `bwe_n` both high, `we_lo_n` and `we_hi_n` have no effect. The cycle is a read, and the stored word is unchanged.
- R6: A read in the cycle right after a write to the same address returns the newly written value for each half that was written, and the stored value for the other half.
- R7: A cycle with `req_valid` low produces no valid output in its own output slot. The read issued one cycle before it is still delivered.
- R8: `oe_n` high forces `rd_valid` to 0 and `rd_data` to zero without waiting for a clock. Lowering `oe_n` again restores the registered word.
- R9: The output slot that belongs to a write cycle shows `rd_valid` 0 and `rd_data` zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the pipeline |
| req_valid | input | 1 | Access selected this cycle |
| req_addr | input | ADDR_W | Word address |
| wr_data | input | 18 | Write word (bits 15:0 data, bit 16 low parity, bit 17 high parity) |
| gw_n | input | 1 | Global write, active low, writes both halves |
| bwe_n | input | 1 | Byte-write enable, active low, qualifies the half enables |
| we_lo_n | input | 1 | Low-half write enable, active low |
| we_hi_n | input | 1 | High-half write enable, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rd_data | output | 18 | Registered read word, zero when not valid |
| rd_valid | output | 1 | Read word valid on `rd_data` |

## Verification
The bench targets a read right after a single-half write to the same address. A core without the forwarding path returns the stale word there, and one that forwards whole words corrupts the half that was not written. It also checks half enables given while the byte-write enable is high, which a core that skips the qualification would store. Global write is checked with the half enables held high, which a core that gives priority to the wrong control would ignore. The bench also aims at a deselect right after a read: a core that deselects without the pipeline delay loses that read's data, and one that delays too long shows a stale valid beat. Finally, it flips the output enable in the middle of a cycle, which catches a core that registers the enable.

// File: rtl/sram_core_pkg.sv
package sram_core_pkg;

    localparam int HALF_DATA_W = 8;
    localparam int HALVES      = 2;
    localparam int HALF_W      = HALF_DATA_W + 1;
    localparam int WORD_W      = HALVES * HALF_W;
    localparam int PAR_BASE    = HALVES * HALF_DATA_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [HALF_W-1:0] half_t;
    typedef logic [HALVES-1:0] hmask_t;

    // control carried along the pipeline
    typedef struct packed {
        logic   vld;
        logic   wr;
        hmask_t mask;
    } stage_ctl_t;

    // half h = {parity bit, eight data bits}
    function automatic half_t half_of(word_t w, int h);
        return {w[PAR_BASE + h], w[h*HALF_DATA_W +: HALF_DATA_W]};
    endfunction

    function automatic word_t with_half(word_t w, int h, half_t v);
        word_t r;
        r = w;
        r[h*HALF_DATA_W +: HALF_DATA_W] = v[HALF_DATA_W-1:0];
        r[PAR_BASE + h] = v[HALF_W-1];
        return r;
    endfunction

endpackage

// File: rtl/sram_wr_qual.sv
module sram_wr_qual
    import sram_core_pkg::*;
(
    input  logic   gw_n,
    input  logic   bwe_n,
    input  hmask_t half_we_n,
    output hmask_t mask
);
    // global write overrides; half enables count only under byte-write enable
    for (genvar h = 0; h < HALVES; h++) begin : g_half
        assign mask[h] = !gw_n || (!bwe_n && !half_we_n[h]);
    end
endmodule

// File: rtl/sram_half_bank.sv
module sram_half_bank
    import sram_core_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  half_t             wr_half,
    input  logic [ADDR_W-1:0] rd_addr,
    output half_t             rd_half
);
    localparam int DEPTH = 1 << ADDR_W;

    half_t mem [DEPTH];

    // read returns the pre-write contents on a same-edge collision
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_half;
        end
        rd_half <= mem[rd_addr];
    end
endmodule

// File: rtl/sram_fwd_merge.sv
module sram_fwd_merge
    import sram_core_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  word_t             arr_word,
    input  logic              fwd_wr,
    input  hmask_t            fwd_mask,
    input  logic [ADDR_W-1:0] fwd_addr,
    input  logic [ADDR_W-1:0] rd_addr,
    input  word_t             fwd_word,
    output word_t             out_word
);
    logic hit;

    assign hit = fwd_wr && (fwd_addr == rd_addr);

    // replace only the halves that the colliding write touched
    always_comb begin
        out_word = arr_word;
        for (int h = 0; h < HALVES; h++) begin
            if (hit && fwd_mask[h]) begin
                out_word = with_half(out_word, h, half_of(fwd_word, h));
            end
        end
    end
endmodule

// File: rtl/sram_pipe_core.sv
module sram_pipe_core
    import sram_core_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic              we_lo_n,
    input  logic              we_hi_n,
    input  logic              oe_n,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid
);
    hmask_t     in_mask;
    stage_ctl_t cap_ctl, cmt_ctl;
    logic [ADDR_W-1:0] cap_addr, cmt_addr;
    word_t      cap_data, cmt_data;
    half_t      bank_wdata [HALVES];
    half_t      arr_half   [HALVES];
    word_t      arr_word, rd_word, out_q;
    logic       out_vld;

    sram_wr_qual u_qual (
        .gw_n      (gw_n),
        .bwe_n     (bwe_n),
        .half_we_n ({we_hi_n, we_lo_n}),
        .mask      (in_mask)
    );

    // capture stage, then commit stage (the write lands in the array at commit)
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_ctl <= '0;
            cmt_ctl <= '0;
        end else begin
            cap_ctl.vld  <= req_valid;
            cap_ctl.wr   <= req_valid && (|in_mask);
            cap_ctl.mask <= req_valid ? in_mask : '0;
            cmt_ctl      <= cap_ctl;
        end
    end

    always_ff @(posedge clk) begin
        cap_addr <= req_addr;
        cap_data <= wr_data;
        cmt_addr <= cap_addr;
        cmt_data <= cap_data;
    end

    for (genvar h = 0; h < HALVES; h++) begin : g_bank
        assign bank_wdata[h] = half_of(cap_data, h);

        sram_half_bank #(.ADDR_W(ADDR_W)) u_bank (
            .clk     (clk),
            .wr_en   (cap_ctl.wr && cap_ctl.mask[h]),
            .wr_addr (cap_addr),
            .wr_half (bank_wdata[h]),
            .rd_addr (req_addr),
            .rd_half (arr_half[h])
        );
    end

    always_comb begin
        arr_word = '0;
        for (int h = 0; h < HALVES; h++) begin
            arr_word = with_half(arr_word, h, arr_half[h]);
        end
    end

    sram_fwd_merge #(.ADDR_W(ADDR_W)) u_merge (
        .arr_word (arr_word),
        .fwd_wr   (cmt_ctl.wr),
        .fwd_mask (cmt_ctl.mask),
        .fwd_addr (cmt_addr),
        .rd_addr  (cap_addr),
        .fwd_word (cmt_data),
        .out_word (rd_word)
    );

    // output register; deselect and write slots park at zero
    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            out_q   <= '0;
        end else begin
            out_vld <= cap_ctl.vld && !cap_ctl.wr;
            out_q   <= (cap_ctl.vld && !cap_ctl.wr) ? rd_word : '0;
        end
    end

    assign rd_valid = out_vld && !oe_n;
    assign rd_data  = rd_valid ? out_q : '0;
endmodule

// File: rtl/sram_pipe_core_chk.sv
module sram_pipe_core_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        gw_n,
    input logic        bwe_n,
    input logic        we_lo_n,
    input logic        we_hi_n,
    input logic        oe_n,
    input logic [17:0] rd_data,
    input logic        rd_valid
);
    logic is_wr;
    assign is_wr = !gw_n || (!bwe_n && (!we_lo_n || !we_hi_n));

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!rd_valid && rd_data == '0));

    assert_read_lat_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !is_wr) |-> ##2 (rd_valid || oe_n));

    assert_bwe_off_read_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && gw_n && bwe_n) |-> ##2 (rd_valid || oe_n));

    assert_desel_slot_R7: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> ##2 !rd_valid);

    assert_oe_gate_R8: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (!rd_valid && rd_data == '0));

    assert_wr_slot_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && is_wr) |-> ##2 (!rd_valid && rd_data == '0));
endmodule

bind sram_pipe_core sram_pipe_core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .gw_n      (gw_n),
    .bwe_n     (bwe_n),
    .we_lo_n   (we_lo_n),
    .we_hi_n   (we_hi_n),
    .oe_n      (oe_n),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
);

// File: tb/sram_pipe_core_bench.sv
module sram_pipe_core_bench;
    localparam int AW = 6;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [17:0]   wr_data = '0;
    logic          gw_n = 1'b1, bwe_n = 1'b1, we_lo_n = 1'b1, we_hi_n = 1'b1, oe_n = 1'b0;
    logic [17:0]   rd_data;
    logic          rd_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [17:0] ref_mem [NW];
    bit          q_v [$];
    logic [17:0] q_d [$];
    string       q_t [$];

    always #5 clk = ~clk;

    sram_pipe_core #(.ADDR_W(AW)) u_sram_pipe_core (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .wr_data(wr_data), .gw_n(gw_n), .bwe_n(bwe_n), .we_lo_n(we_lo_n),
        .we_hi_n(we_hi_n), .oe_n(oe_n), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic check(string tag, logic [17:0] ad, logic av, logic [17:0] ed, logic ev);
        n_chk++;
        if (ad !== ed || av !== ev) begin
            n_bad++;
            $display("FAIL %s: rd_valid=%b rd_data=%h, expected rd_valid=%b rd_data=%h",
                     tag, av, ad, ev, ed);
        end
    endtask

    // one clock: check the slot due now, then present a new request
    task automatic cyc(bit v, int a, logic [17:0] d, bit g, bit b, bit lo, bit hi,
                       bit oe, string rtag, bit probe);
        bit          ev, ml, mh;
        logic [17:0] ed;
        string       et;
        @(negedge clk);
        ev = q_v.pop_front(); ed = q_d.pop_front(); et = q_t.pop_front();
        check(et, rd_data, rd_valid, (ev && !oe_n) ? ed : 18'h0, ev && !oe_n);
        if (probe) begin
            oe_n = 1'b1; #1;
            check("R8", rd_data, rd_valid, 18'h0, 1'b0);
            oe_n = 1'b0; #1;
            check("R8", rd_data, rd_valid, ev ? ed : 18'h0, ev);
        end
        req_valid = v; req_addr = a[AW-1:0]; wr_data = d;
        gw_n = g; bwe_n = b; we_lo_n = lo; we_hi_n = hi; oe_n = oe;
        ml = !g || (!b && !lo);
        mh = !g || (!b && !hi);
        if (v && (ml || mh)) begin
            if (ml) begin ref_mem[a][7:0] = d[7:0];  ref_mem[a][16] = d[16]; end
            if (mh) begin ref_mem[a][15:8] = d[15:8]; ref_mem[a][17] = d[17]; end
            q_v.push_back(1'b0); q_d.push_back(18'h0); q_t.push_back("R9");
        end else if (v) begin
            q_v.push_back(1'b1); q_d.push_back(ref_mem[a]); q_t.push_back(rtag);
        end else begin
            q_v.push_back(1'b0); q_d.push_back(18'h0); q_t.push_back("R7");
        end
    endtask

    task automatic rd(int a, string t);
        cyc(1, a, 18'h0, 1, 1, 1, 1, 0, t, 0);
    endtask
    task automatic wr_lo(int a, logic [17:0] d);
        cyc(1, a, d, 1, 0, 0, 1, 0, "R9", 0);
    endtask
    task automatic wr_hi(int a, logic [17:0] d);
        cyc(1, a, d, 1, 0, 1, 0, 0, "R9", 0);
    endtask
    task automatic idle();
        cyc(0, 0, 18'h0, 1, 1, 1, 1, 0, "R7", 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", rd_data, rd_valid, 18'h0, 1'b0);
        rst = 1'b0;
        q_v.push_back(1'b0); q_d.push_back(18'h0); q_t.push_back("R1");
        q_v.push_back(1'b0); q_d.push_back(18'h0); q_t.push_back("R1");

        // R3: global write with byte-write and half enables all high
        for (int a = 0; a < NW; a++)
            cyc(1, a, 18'((a * 18'h0a5b3) ^ 18'h2c3c1), 0, 1, 1, 1, 0, "R9", 0);
        for (int a = 0; a < NW; a++) rd(a, "R3");
        // R2: back-to-back reads across a pattern
        for (int a = NW - 1; a >= 0; a -= 7) rd(a, "R2");

        // R4: single-half writes, read later
        wr_lo(5, 18'h3ffff);
        wr_hi(6, 18'h00000);
        idle();
        rd(5, "R4");
        rd(6, "R4");

        // R5: half enables with byte-write off; then reread
        cyc(1, 7, 18'h15555, 1, 1, 0, 0, 0, "R5", 0);
        idle();
        rd(7, "R5");

        // R6: pass-through per half
        wr_lo(9, 18'h1abcd);
        rd(9, "R6");
        wr_hi(10, 18'h2f00f);
        rd(10, "R6");
        cyc(1, 11, 18'h3c3c3, 0, 0, 0, 0, 0, "R9", 0);
        rd(11, "R6");
        wr_lo(12, 18'h01111);
        wr_hi(12, 18'h22222);
        rd(12, "R6");
        wr_lo(13, 18'h0aaaa);
        rd(14, "R6");
        rd(13, "R6");

        // R7: deselect right after a read, then another read
        rd(20, "R7");
        idle();
        rd(21, "R7");
        idle();
        idle();

        // R8: output enable held high and toggled mid-cycle
        rd(22, "R8");
        cyc(1, 23, 18'h0, 1, 1, 1, 1, 1, "R8", 0);
        cyc(1, 24, 18'h0, 1, 1, 1, 1, 0, "R8", 0);
        cyc(1, 25, 18'h0, 1, 1, 1, 1, 0, "R8", 0);
        cyc(1, 26, 18'h0, 1, 1, 1, 1, 0, "R8", 1);

        // mixed traffic on a small address window
        for (int i = 0; i < 400; i++) begin
            int a;
            int k;
            a = 32 + ($urandom % 4);
            k = $urandom % 6;
            case (k)
                0: wr_lo(a, 18'($urandom));
                1: wr_hi(a, 18'($urandom));
                2: cyc(1, a, 18'($urandom), 0, $urandom % 2, $urandom % 2, $urandom % 2, 0, "R3", 0);
                3: cyc(1, a, 18'($urandom), 1, 1, $urandom % 2, $urandom % 2, 0, "R5", 0);
                4: idle();
                default: rd(a, "R6");
            endcase
        end
        idle();
        idle();
        idle();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule